// File: doc/BRIEF.md
# Word memory with reloadable image

This block is a word-addressed store of 16-bit words for a small unpipelined processor. The processor reads through one port and writes through a single synchronous write port. A second, independent read port lets a bench or a debug probe look at any word without disturbing the processor. Both read ports are combinational, so a read address presented in a cycle returns its word within that same cycle.

The address space is 16 bits wide, but only the lowest 128 words have storage behind them. Every address above that range reads as zero and swallows writes. A synchronous reset does not clear the array. It reloads a fixed program-and-data image that is computed inside the block, so a processor held in reset always restarts from the same known contents.

Top module: `wmem_core`

## Requirements
- R1: In the cycle after `rst` was high at a rising edge, the word at every index i from 0 to 127 equals the low 16 bits of (i * 40503) XOR 23130 (hex 9E37 and 5A5A).
- R2: When `wr_en` is high, `rst` is low and `wr_addr` is below 128 at a rising edge, the word at `wr_addr` holds `wr_data` after that edge.
- R3: A rising edge with `wr_en` low changes no stored word.
- R4: Either read port returns 16'h0000 whenever its address is 128 or above.
- R5: A write whose address is 128 or above changes no stored word. In particular, it does not alias onto the word at the address modulo 128.
- R6: Read data follows its address combinationally: changing a read address between clock edges changes the data without any clock edge.
- R7: When a read address equals the write address in a write cycle, the read returns the old word until the edge and the new word after it.
- R8: The debug port and the processor port read the same contents independently; equal addresses give equal data, and distinct addresses each give their own word in the same cycle.
- R9: Reset takes priority over a write in the same cycle, and reset restores words that earlier writes had overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous, active-high; reloads the built-in image |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Word to write |
| cpu_addr | input | 16 | Processor read address |
| cpu_rdata | output | 16 | Processor read data, combinational |
| dbg_addr | input | 16 | Inspection read address |
| dbg_rdata | output | 16 | Inspection read data, combinational |

## Verification
The checker watches several properties on every cycle: zero data above the implemented range on both ports, agreement of the two ports at equal addresses, that a landed write shows up at its address, that contents hold across idle edges, and that the image is present right after reset. Some behaviours can only be shown by the bench's scenarios. These include the full 128-word image scan, the absence of aliasing for out-of-range writes, combinational address changes between edges, the old-value read during a write, and reset overriding a simultaneous write. The bench compares both ports against a behavioural model in every cycle.

// File: rtl/wmem_pkg.sv
package wmem_pkg;

  localparam int unsigned IMG_MUL = 32'd40503;
  localparam int unsigned IMG_XOR = 32'd23130;

  // Built-in image word for storage index idx
  function automatic logic [31:0] img_word(input int unsigned idx);
    logic [31:0] t;
    t = (idx * IMG_MUL) ^ IMG_XOR;
    return {16'h0000, t[15:0]};
  endfunction

endpackage

// File: rtl/wmem_decode.sv
module wmem_decode #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    hit = (32'(addr) < 32'(DEPTH));
    idx = addr[IDX_W-1:0];
  end
endmodule

// File: rtl/wmem_store.sv
module wmem_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic [DATA_W-1:0] rd_word [NRD]
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        cells[i] <= DATA_W'(wmem_pkg::img_word(i));
    end else if (we) begin
      cells[widx] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb rd_word[p] = cells[rd_idx[p]];
  end
endmodule

// File: rtl/wmem_core.sv
module wmem_core #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NRD   = 2;

  logic              w_hit;
  logic [IDX_W-1:0]  w_idx;
  logic [ADDR_W-1:0] r_addr [NRD];
  logic              r_hit  [NRD];
  logic [IDX_W-1:0]  r_idx  [NRD];
  logic [DATA_W-1:0] r_word [NRD];
  logic [DATA_W-1:0] r_out  [NRD];

  wmem_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wdec (
    .addr(wr_addr), .hit(w_hit), .idx(w_idx)
  );

  always_comb begin
    r_addr[0] = cpu_addr;
    r_addr[1] = dbg_addr;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    wmem_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rdec (
      .addr(r_addr[p]), .hit(r_hit[p]), .idx(r_idx[p])
    );
    always_comb r_out[p] = r_hit[p] ? r_word[p] : '0;
  end

  wmem_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NRD(NRD)) u_store (
    .clk(clk), .rst(rst), .we(wr_en && w_hit), .widx(w_idx),
    .wdata(wr_data), .rd_idx(r_idx), .rd_word(r_word)
  );

  always_comb begin
    cpu_rdata = r_out[0];
    dbg_rdata = r_out[1];
  end
endmodule

// File: rtl/wmem_core_chk.sv
module wmem_core_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic [DATA_W-1:0] dbg_rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  function automatic logic [DATA_W-1:0] img_at(input logic [ADDR_W-1:0] a);
    return DATA_W'(wmem_pkg::img_word(int'(a[IDX_W-1:0])));
  endfunction

  // R4: out-of-range reads are zero on both ports
  a_r4_cpu_high_zero: assert property (@(posedge clk) disable iff (rst)
    (32'(cpu_addr) >= 32'(DEPTH)) |-> (cpu_rdata == '0));
  a_r4_dbg_high_zero: assert property (@(posedge clk) disable iff (rst)
    (32'(dbg_addr) >= 32'(DEPTH)) |-> (dbg_rdata == '0));

  // R8: equal addresses give equal data
  a_r8_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr == dbg_addr) |-> (cpu_rdata == dbg_rdata));

  // R2: an in-range write is visible after its edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (32'(wr_addr) < 32'(DEPTH)))
      |=> ((cpu_addr != $past(wr_addr)) || (cpu_rdata == $past(wr_data))));

  // R3: an idle edge leaves the word at a held address unchanged
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ((cpu_addr != $past(cpu_addr)) || $stable(cpu_rdata)));

  // R1: image present right after reset
  a_r1_image_loaded: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((32'(cpu_addr) >= 32'(DEPTH)) || (cpu_rdata == img_at(cpu_addr))));
endmodule

bind wmem_core wmem_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata)
);

// File: tb/wmem_core_test.sv
module wmem_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, cpu_addr = '0, dbg_addr = '0;
  logic [15:0] cpu_rdata, dbg_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] model [128];

  always #5 clk = ~clk;

  wmem_core uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [15:0] image_of(input int i);
    logic [31:0] t;
    t = (i * 40503) ^ 23130;
    return t[15:0];
  endfunction

  function automatic logic [15:0] expect_at(input logic [15:0] a);
    return (a < 16'd128) ? model[a[6:0]] : 16'h0000;
  endfunction

  task automatic reload_model();
    for (int i = 0; i < 128; i++) model[i] = image_of(i);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: drive after the falling edge, compare before the rising edge, advance the model
  task automatic cyc(input string tag, input logic r, input logic we, input logic [15:0] wa,
                     input logic [15:0] wd, input logic [15:0] ca, input logic [15:0] da);
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd; cpu_addr = ca; dbg_addr = da;
    #2;
    chk(tag, cpu_rdata, expect_at(ca));
    chk(tag, dbg_rdata, expect_at(da));
    @(posedge clk);
    if (r) reload_model();
    else if (we && wa < 16'd128) model[wa[6:0]] = wd;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    @(posedge clk);
    reload_model();
    @(negedge clk);
    cyc("R9 reset held", 1, 0, 0, 0, 0, 0);

    // R1 and R8: full image scan, debug port walking the other way
    for (int i = 0; i < 128; i++)
      cyc("R1/R8 image scan", 0, 0, 0, 0, 16'(i), 16'(127 - i));

    // R2: writes at both ends and the middle
    cyc("R2 write 0", 0, 1, 16'd0, 16'hBEEF, 16'd1, 16'd2);
    cyc("R2 write 127", 0, 1, 16'd127, 16'h1234, 16'd0, 16'd0);
    cyc("R2 write 64", 0, 1, 16'd64, 16'h0000, 16'd127, 16'd0);
    cyc("R2 readback", 0, 0, 0, 0, 16'd64, 16'd127);

    // R3: enable low with live data
    cyc("R3 idle edge", 0, 0, 16'd10, 16'hDEAD, 16'd10, 16'd11);
    cyc("R3 idle check", 0, 0, 0, 0, 16'd10, 16'd10);

    // R4: high addresses
    cyc("R4 high reads", 0, 0, 0, 0, 16'd128, 16'hFFFF);
    cyc("R4 high reads", 0, 0, 0, 0, 16'h8000, 16'd200);

    // R5: out-of-range writes must not alias
    cyc("R5 high write", 0, 1, 16'd133, 16'hAAAA, 16'd5, 16'd133);
    cyc("R5 high write", 0, 1, 16'hFF85, 16'h5555, 16'd5, 16'hFF85);
    cyc("R5 alias check", 0, 0, 0, 0, 16'd5, 16'd133);

    // R7: read-during-write sees the old word, then the new one
    cyc("R7 same-cycle old", 0, 1, 16'd20, 16'hCAFE, 16'd20, 16'd20);
    cyc("R7 next-cycle new", 0, 0, 0, 0, 16'd20, 16'd20);

    // R6: address changes between edges, no clock
    rst = 0; wr_en = 0;
    cpu_addr = 16'd30; dbg_addr = 16'd31; #1;
    chk("R6 comb read", cpu_rdata, expect_at(16'd30));
    chk("R6 comb read", dbg_rdata, expect_at(16'd31));
    cpu_addr = 16'd20; dbg_addr = 16'd300; #1;
    chk("R6 comb read", cpu_rdata, expect_at(16'd20));
    chk("R6 comb read", dbg_rdata, expect_at(16'd300));
    @(negedge clk);

    // R9: reset with a simultaneous write, then the image is back everywhere
    cyc("R9 reset+write", 1, 1, 16'd0, 16'h7777, 16'd0, 16'd20);
    for (int i = 0; i < 128; i++)
      cyc("R9 image restored", 0, 0, 0, 0, 16'(i), 16'(i));

    done = 1;
    summary();
    $finish;
  end
endmodule